// File: doc/BRIEF.md
# Interval Timer Channel

A single down-counting timer channel that turns a slow timer-clock enable into either a periodic one-tick pulse or a square wave. Software programs it through two write strobes that share one 8-bit data bus. A control-word write picks the counting radix, the operating mode and the order in which the bytes of the 16-bit reload value arrive. Data writes then deliver that reload value.

Once the last byte has arrived, the channel starts on the next timer tick and runs until a new control word stops it. A typical use is a periodic interrupt: a reload of 11931 with a tick of about 1.19 MHz gives an output at about 100 Hz. Only channel 0 exists, and control words that address another channel are dropped. The gate is treated as permanently active.

Top module: `interval_timer_ch`

## Requirements
- R1: After reset the output `out_pulse` is high and stays high until a valid control word and a complete reload value have been written.
- R2: Control word fields: bit 0 selects binary (0) or BCD (1) counting. Bits 3:1 select the mode: 3'b010 is the rate generator and 3'b011 is the square wave. Bits 5:4 select the access order: 2'b01 is low byte only, 2'b10 is high byte only, and 2'b11 is low byte then high byte. Bits 7:6 select the channel, and only 0 is accepted. A control word with a non-zero channel, access 2'b00 or any other mode has no effect: a running count carries on undisturbed.
- R3: A valid control word stops the count, drives the output high and resets the byte pointer. Counting resumes only after a new reload value is complete.
- R4: In low-only access a data byte b gives a reload of {8'h00,b}. In high-only access it gives {b,8'h00}. In low-then-high access the first write supplies the low byte and the second supplies the high byte.
- R5: The counter loads the reload value on the first tick after the final reload byte has been written. The output is high in the cycle after that tick.
- R6: In rate-generator mode with reload N, the output has a period of N ticks. It is low only for the one tick in which the count is 1, and then the counter reloads.
- R7: In square-wave mode with reload N, the output is high for ceil(N/2) ticks and low for floor(N/2) ticks, starting high.
- R8: A reload of 0 counts as 65536 in binary mode and as 10000 in BCD mode.
- R9: In BCD mode the reload and count are four decimal digits. Each digit wraps from 0 to 9 and borrows from the next digit.
- R10: The count changes only on a tick.
- R11: A new complete reload value written while the channel runs, with no new control word, restarts the count from that value on the next tick.
- R12: Data writes made before any valid control word has been accepted are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer-clock enable, one count step per cycle it is high |
| wr_ctrl | input | 1 | Strobe: `wdata` holds a control word |
| wr_data | input | 1 | Strobe: `wdata` holds a reload byte |
| wdata | input | 8 | Shared write data bus |
| out_pulse | output | 1 | Timer output |

## Verification
The output is a combinational function of registered state. It therefore reflects each clock edge's update in the same cycle and is compared with a behavioural model on every falling edge. A final reload byte sets a pending flag on its own edge. The count is loaded at the first later edge where `tick` is high, so the first output phase is counted from that cycle. A control word takes effect at its own edge, and the output is high from the next cycle on. The model advances a phase index per tick, modulo the decoded reload length. This places every rate pulse and square-wave edge on an exact tick, including when ticks are spaced several clocks apart.

// File: rtl/interval_timer_ch.sv
module interval_timer_ch (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_ctrl,
  input  logic       wr_data,
  input  logic [7:0] wdata,
  output logic       out_pulse
);

  localparam int DIGITS = 4;

  logic        cfg_ok, bcd_q, sq_q, ptr_q, pend_q, run_q, phase_q, stretch_q;
  logic [1:0]  acc_q;
  logic [7:0]  lo_q;
  logic [15:0] reload_q, cnt_q, new_reload;

  function automatic logic [15:0] dec1(input logic [15:0] x, input logic bcd);
    logic [15:0] r;
    logic br;
    r  = x;
    br = 1'b1;
    if (!bcd) return x - 16'd1;
    for (int i = 0; i < DIGITS; i++) begin
      if (br) begin
        if (r[i*4 +: 4] == 4'd0) r[i*4 +: 4] = 4'd9;
        else begin
          r[i*4 +: 4] = r[i*4 +: 4] - 4'd1;
          br = 1'b0;
        end
      end
    end
    return r;
  endfunction

  function automatic logic bcd_ok(input logic [15:0] x);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < DIGITS; i++)
      if (x[i*4 +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  wire ctrl_ok = wr_ctrl && (wdata[7:6] == 2'b00) && (wdata[5:4] != 2'b00)
                 && (wdata[3:2] == 2'b01);
  wire [15:0] even_rl = {reload_q[15:1], 1'b0};
  wire [15:0] cnt_m1  = dec1(cnt_q, bcd_q);
  wire [15:0] cnt_m2  = dec1(cnt_m1, bcd_q);

  always_comb begin
    case (acc_q)
      2'b01:   new_reload = {8'h00, wdata};
      2'b10:   new_reload = {wdata, 8'h00};
      default: new_reload = {wdata, lo_q};
    endcase
  end

  assign out_pulse = !run_q || (sq_q ? phase_q : (cnt_q != 16'd1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_ok    <= 1'b0;
      bcd_q     <= 1'b0;
      sq_q      <= 1'b0;
      acc_q     <= 2'b00;
      ptr_q     <= 1'b0;
      pend_q    <= 1'b0;
      run_q     <= 1'b0;
      phase_q   <= 1'b1;
      stretch_q <= 1'b0;
      lo_q      <= 8'h00;
      reload_q  <= 16'h0000;
      cnt_q     <= 16'h0000;
    end else if (ctrl_ok) begin
      cfg_ok <= 1'b1;
      bcd_q  <= wdata[0];
      sq_q   <= wdata[1];
      acc_q  <= wdata[5:4];
      ptr_q  <= 1'b0;
      pend_q <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      if (tick && pend_q) begin
        run_q     <= 1'b1;
        pend_q    <= 1'b0;
        phase_q   <= 1'b1;
        stretch_q <= 1'b0;
        cnt_q     <= sq_q ? even_rl : reload_q;
      end else if (tick && run_q) begin
        if (!sq_q) begin
          cnt_q <= (cnt_q == 16'd1) ? reload_q : cnt_m1;
        end else if (cnt_q == 16'd2) begin
          if (phase_q && reload_q[0] && !stretch_q) stretch_q <= 1'b1;
          else begin
            stretch_q <= 1'b0;
            phase_q   <= !phase_q;
            cnt_q     <= even_rl;
          end
        end else begin
          cnt_q <= cnt_m2;
        end
      end
      if (wr_data && cfg_ok) begin
        if (acc_q == 2'b11 && !ptr_q) begin
          lo_q  <= wdata;
          ptr_q <= 1'b1;
        end else begin
          reload_q <= new_reload;
          ptr_q    <= 1'b0;
          pend_q   <= 1'b1;
        end
      end
    end
  end

  // R10
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !tick && !wr_ctrl) |=> $stable(cnt_q));

  // R6
  low_one_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !sq_q && !out_pulse && tick && !pend_q && !wr_ctrl && reload_q != 16'd1)
    |=> out_pulse);

  // R5
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && tick && !wr_ctrl && reload_q != 16'd1) |=> (run_q && out_pulse));

  // R3
  ctrl_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_ok |=> (!run_q && out_pulse && !pend_q));

  // R9
  bcd_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && bcd_q && bcd_ok(cnt_q) && bcd_ok(reload_q) && !wr_ctrl && !wr_data)
    |=> bcd_ok(cnt_q));

  // R2
  other_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && wdata[7:6] != 2'b00 && !wr_data && !tick)
    |=> ($stable(cnt_q) && $stable(run_q) && $stable({bcd_q, sq_q, acc_q})));

endmodule

// File: tb/interval_timer_ch_bench.sv
module interval_timer_ch_bench;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_ctrl = 1'b0, wr_data = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic out_pulse;
  int checks = 0, fails = 0, cyc = 0, tdiv = 1;
  string req = "R1";

  always #2 clk = ~clk;

  interval_timer_ch u_interval_timer_ch (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_ctrl(wr_ctrl),
    .wr_data(wr_data), .wdata(wdata), .out_pulse(out_pulse));

  logic m_valid, m_bcd, m_sq, m_ptr, m_pend, m_run;
  logic [1:0]  m_acc;
  logic [7:0]  m_lo;
  logic [15:0] m_rl;
  int m_p, m_n;

  function automatic int nval(input logic [15:0] r, input logic b);
    int v;
    if (b) v = int'(r[15:12]) * 1000 + int'(r[11:8]) * 100 + int'(r[7:4]) * 10 + int'(r[3:0]);
    else   v = int'(r);
    if (v == 0) v = b ? 10000 : 65536;
    return v;
  endfunction

  function automatic logic m_out();
    if (!m_run) return 1'b1;
    if (m_sq)   return m_p < (m_n + 1) / 2;
    return m_p != m_n - 1;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      m_valid = 0; m_bcd = 0; m_sq = 0; m_ptr = 0; m_pend = 0; m_run = 0;
      m_acc = 0; m_lo = 0; m_rl = 0; m_p = 0; m_n = 1;
    end else if (wr_ctrl && wdata[7:6] == 0 && wdata[5:4] != 0 && wdata[3:1] inside {3'b010, 3'b011}) begin
      m_valid = 1; m_bcd = wdata[0]; m_sq = wdata[1]; m_acc = wdata[5:4];
      m_ptr = 0; m_pend = 0; m_run = 0;
    end else begin
      if (tick) begin
        if (m_pend) begin m_n = nval(m_rl, m_bcd); m_p = 0; m_run = 1; m_pend = 0; end
        else if (m_run) m_p = (m_p + 1) % m_n;
      end
      if (wr_data && m_valid) begin
        if (m_acc == 2'b01)      begin m_rl = {8'h00, wdata}; m_pend = 1; end
        else if (m_acc == 2'b10) begin m_rl = {wdata, 8'h00}; m_pend = 1; end
        else if (!m_ptr)         begin m_lo = wdata; m_ptr = 1; end
        else begin m_rl = {wdata, m_lo}; m_ptr = 0; m_pend = 1; end
      end
    end
  end

  always @(negedge clk) begin
    logic e;
    e = rst_n ? m_out() : 1'b1;
    checks++;
    if (out_pulse !== e) begin
      fails++;
      $display("FAIL %s out_pulse=%b expected=%b cycle %0d", req, out_pulse, e, cyc);
    end
    tick = (tdiv <= 1) ? 1'b1 : ((cyc % tdiv) == 0);
    if (cyc > 190000) begin
      fails++;
      $display("FAIL watchdog expired cycle %0d", cyc);
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  task automatic wc(input logic [7:0] v);
    @(negedge clk); wr_ctrl = 1; wdata = v;
    @(negedge clk); wr_ctrl = 0;
  endtask
  task automatic wd(input logic [7:0] v);
    @(negedge clk); wr_data = 1; wdata = v;
    @(negedge clk); wr_data = 0;
  endtask
  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    req = "R1"; run(5); rst_n = 1; run(10);
    req = "R12"; wd(8'h05); wd(8'h00); run(20);
    req = "R4/R5/R6 rate LH"; wc(8'h34); wd(8'h05); wd(8'h00); run(40);
    req = "R2 ignored words"; wc(8'h74); run(7); wc(8'h04); run(5); wc(8'h30); run(5); wc(8'hB4); run(9);
    req = "R10 sparse ticks"; tdiv = 3; run(60); tdiv = 1;
    req = "R7 square odd"; wc(8'h36); wd(8'h07); wd(8'h00); run(40);
    req = "R7 square even"; wc(8'h36); wd(8'h08); wd(8'h00); tdiv = 2; run(50); tdiv = 1;
    req = "R4 low only"; wc(8'h14); wd(8'h09); run(40);
    req = "R4 high only"; wc(8'h24); wd(8'h01); run(600);
    req = "R3 pointer reset"; wc(8'h34); wd(8'hAA); run(3); wc(8'h34); run(4); wd(8'h03); wd(8'h00); run(20);
    req = "R11 reload while running"; wd(8'h06); wd(8'h00); run(30);
    req = "R9 BCD 12"; wc(8'h35); wd(8'h12); wd(8'h00); run(60);
    req = "R9 BCD 100"; wc(8'h35); wd(8'h00); wd(8'h01); run(250);
    req = "R7/R9 BCD square 15"; wc(8'h37); wd(8'h15); wd(8'h00); run(60);
    req = "R8 BCD zero"; wc(8'h35); wd(8'h00); wd(8'h00); run(10100);
    req = "R8 binary zero"; wc(8'h34); wd(8'h00); wd(8'h00); run(65700);
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule